// File: doc/BRIEF.md
# Three-Queue Transmit Frame Scheduler

This block decides which of three transmit queues may start the next Ethernet frame. Queue 0 carries best-effort traffic and always uses a plain rule: it may send if it holds a complete frame. Queues 1 and 2 carry shaped traffic. Each of them keeps a signed credit and may send only while it has a frame waiting and its credit is above zero. Software can switch the shaping off for queue 1 alone or for both shaped queues. A queue whose shaping is off uses the plain rule. A threshold mode lets a queue under the plain rule become eligible early, once its partial frame reaches a programmed byte count.

The block is a three-state machine. In IDLE it compares the eligible queues and records the winner by fixed priority: queue 2 first, then queue 1, then queue 0. It then enters ARMED and drives a one-hot grant. The frame-start strobe of the granted queue moves it to SEND. The frame-end strobe of the granted queue, seen in ARMED or in SEND, returns it to IDLE. A shaped credit rises by the idle slope while its queue waits and falls by the send slope while its queue is in SEND. The credit is clamped between two programmable limits. The two shaped credits are brought out as ports so that they can be monitored.

Top module: `txsched_top`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it falls, `grant` is 0, `grant_valid` is 0 and both credit outputs are 0.
- R2: Queue 0 is eligible whenever its `frame_count` is non-zero. The grant follows one clock edge after eligibility is seen in IDLE. `grant` bit c is the grant for queue c.
- R3: While `thr_en` is 1, a queue under the plain rule is also eligible when its `part_bytes` is greater than or equal to `thr_bytes`. While `thr_en` is 0, partial bytes have no effect.
- R4: A shaped queue is eligible only if its `frame_count` is non-zero and its credit is strictly positive. The threshold mode does not apply to it.
- R5: Each cycle, a shaped credit falls by `send_slope` while its queue is in SEND. Otherwise it rises by `idle_slope` while the queue's `frame_count` is non-zero. This includes the ARMED state.
- R6: A shaped queue with no frames and not in SEND does one of two things. If its credit is positive, the credit becomes 0 at the next edge. If its credit is negative, the credit rises by `idle_slope` but not above 0.
- R7: After each update, a credit is clamped to the range `credit_lo` to `credit_hi`.
- R8: `shaper_off[0]`=1 with `shaper_off[1]`=1 switches off shaping on both queue 1 and queue 2. `shaper_off[0]`=1 with `shaper_off[1]`=0 switches it off on queue 1 only. `shaper_off`=2'b10 is illegal and leaves both queues shaped. A queue with shaping off uses the plain rule, and its credit is held at 0.
- R9: When several queues are eligible in IDLE, queue 2 wins over queue 1, and queue 1 wins over queue 0.
- R10: A grant stays fixed until the `frame_end` strobe of the granted queue. Eligibility changes and the strobes of other queues have no effect on it. After that `frame_end` edge, `grant_valid` is 0 for at least one cycle.
- R11: `grant` has at most one bit set, and `grant_valid` is 1 exactly when one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_count | input | 3 x CNT_W | Complete frames held, per queue |
| part_bytes | input | 3 x BYTE_W | Bytes of the partial frame, per queue |
| frame_start | input | 3 | Frame-start strobe from the MAC, per queue |
| frame_end | input | 3 | Frame-end strobe from the MAC, per queue |
| thr_en | input | 1 | Threshold mode enable |
| thr_bytes | input | BYTE_W | Threshold byte count |
| shaper_off | input | 2 | Shaping disable request (see R8) |
| idle_slope | input | CR_W | Credit gain per waiting cycle |
| send_slope | input | CR_W | Credit loss per sending cycle |
| credit_hi | input | CR_W | Signed upper credit limit |
| credit_lo | input | CR_W | Signed lower credit limit |
| grant | output | 3 | One-hot grant |
| grant_valid | output | 1 | A grant is active |
| credit_ch1 | output | CR_W | Signed credit of queue 1 |
| credit_ch2 | output | CR_W | Signed credit of queue 2 |

## Verification
The bench uses the default widths: a 4-bit frame count, an 11-bit byte count and a 16-bit signed credit. It sets an idle slope of 10 and a send slope of 20. These values let each credit step be predicted as an exact multiple of ten. With them, a low limit of -15 and a high limit of 25 are crossed within a few cycles, so saturation is reached in both directions.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
    localparam int NCH = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } sched_state_t;

    function automatic logic [1:0] pick_winner(input logic [NCH-1:0] elig);
        if (elig[2])      return 2'd2;
        else if (elig[1]) return 2'd1;
        else              return 2'd0;
    endfunction
endpackage

// File: rtl/txsched_elig.sv
module txsched_elig #(
    parameter int CNT_W  = 4,
    parameter int BYTE_W = 11
) (
    input  logic              shaped,
    input  logic [CNT_W-1:0]  count,
    input  logic [BYTE_W-1:0] part,
    input  logic              thr_en,
    input  logic [BYTE_W-1:0] thr_bytes,
    input  logic              credit_pos,
    output logic              eligible
);
    logic has_frame;
    logic thr_hit;

    always_comb begin
        has_frame = |count;
        thr_hit   = thr_en && (part >= thr_bytes);
        if (shaped) eligible = has_frame && credit_pos;
        else        eligible = has_frame || thr_hit;
    end
endmodule

// File: rtl/txsched_credit.sv
module txsched_credit #(
    parameter int CR_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   waiting,
    input  logic                   sending,
    input  logic [CR_W-1:0]        idle_slope,
    input  logic [CR_W-1:0]        send_slope,
    input  logic signed [CR_W-1:0] hi_lim,
    input  logic signed [CR_W-1:0] lo_lim,
    output logic signed [CR_W-1:0] credit
);
    localparam int EW = CR_W + 2;

    logic signed [EW-1:0] cur, up, dn, raw, hi_e, lo_e, nxt;

    always_comb begin
        cur  = signed'({{2{credit[CR_W-1]}}, credit});
        hi_e = signed'({{2{hi_lim[CR_W-1]}}, hi_lim});
        lo_e = signed'({{2{lo_lim[CR_W-1]}}, lo_lim});
        up   = cur + signed'({2'b00, idle_slope});
        dn   = cur - signed'({2'b00, send_slope});
        if (sending)              raw = dn;
        else if (waiting)         raw = up;
        else if (cur > 0)         raw = '0;
        else if (up > 0)          raw = '0;
        else                      raw = up;
        if (raw > hi_e)           nxt = hi_e;
        else if (raw < lo_e)      nxt = lo_e;
        else                      nxt = raw;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) credit <= '0;
        else                credit <= nxt[CR_W-1:0];
    end
endmodule

// File: rtl/txsched_top.sv
module txsched_top
    import txsched_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int BYTE_W = 11,
    parameter int CR_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NCH-1:0][CNT_W-1:0]    frame_count,
    input  logic [NCH-1:0][BYTE_W-1:0]   part_bytes,
    input  logic [NCH-1:0]               frame_start,
    input  logic [NCH-1:0]               frame_end,
    input  logic                         thr_en,
    input  logic [BYTE_W-1:0]            thr_bytes,
    input  logic [1:0]                   shaper_off,
    input  logic [CR_W-1:0]              idle_slope,
    input  logic [CR_W-1:0]              send_slope,
    input  logic signed [CR_W-1:0]       credit_hi,
    input  logic signed [CR_W-1:0]       credit_lo,
    output logic [NCH-1:0]               grant,
    output logic                         grant_valid,
    output logic signed [CR_W-1:0]       credit_ch1,
    output logic signed [CR_W-1:0]       credit_ch2
);
    sched_state_t           state, state_nx;
    logic [1:0]             sel, sel_nx;
    logic [NCH-1:0]         shaped;
    logic [NCH-1:0]         elig;
    logic signed [CR_W-1:0] cred [NCH];

    // Illegal request (queue 2 off, queue 1 on) leaves both shaped.
    always_comb begin
        shaped[0] = 1'b0;
        shaped[1] = !shaper_off[0];
        shaped[2] = !(shaper_off[0] && shaper_off[1]);
    end

    assign cred[0] = '0;

    for (genvar c = 0; c < NCH; c++) begin : g_elig
        txsched_elig #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_elig (
            .shaped     (shaped[c]),
            .count      (frame_count[c]),
            .part       (part_bytes[c]),
            .thr_en     (thr_en),
            .thr_bytes  (thr_bytes),
            .credit_pos (cred[c] > 0),
            .eligible   (elig[c])
        );
    end

    for (genvar c = 1; c < NCH; c++) begin : g_credit
        txsched_credit #(.CR_W(CR_W)) u_credit (
            .clk        (clk),
            .rst        (rst),
            .enable     (shaped[c]),
            .waiting    (|frame_count[c]),
            .sending    ((state == ST_SEND) && (sel == 2'(c))),
            .idle_slope (idle_slope),
            .send_slope (send_slope),
            .hi_lim     (credit_hi),
            .lo_lim     (credit_lo),
            .credit     (cred[c])
        );
    end

    // Next state and winner capture
    always_comb begin
        state_nx = state;
        sel_nx   = sel;
        unique case (state)
            ST_IDLE: begin
                if (|elig) begin
                    state_nx = ST_ARMED;
                    sel_nx   = pick_winner(elig);
                end
            end
            ST_ARMED: begin
                if (frame_end[sel])        state_nx = ST_IDLE;
                else if (frame_start[sel]) state_nx = ST_SEND;
            end
            ST_SEND: begin
                if (frame_end[sel])        state_nx = ST_IDLE;
            end
            default:                       state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sel   <= 2'd0;
        end else begin
            state <= state_nx;
            sel   <= sel_nx;
        end
    end

    // Outputs
    always_comb begin
        grant_valid = (state != ST_IDLE);
        grant       = grant_valid ? (NCH'(1) << sel) : '0;
        credit_ch1  = cred[1];
        credit_ch2  = cred[2];
    end
endmodule

// File: rtl/txsched_chk.sv
module txsched_chk #(
    parameter int CR_W = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic [2:0]             frame_end,
    input logic [1:0]             shaper_off,
    input logic signed [CR_W-1:0] credit_hi,
    input logic signed [CR_W-1:0] credit_lo,
    input logic [2:0]             grant,
    input logic                   grant_valid,
    input logic signed [CR_W-1:0] credit_ch1,
    input logic signed [CR_W-1:0] credit_ch2
);
    a_r11_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (grant_valid == (grant != 3'b000)));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !(|(frame_end & grant))) |=> (grant_valid && $stable(grant)));

    a_r7_clamp: assert property (@(posedge clk) disable iff (rst)
        ($stable(credit_hi) && $stable(credit_lo)) |->
        (credit_ch1 <= credit_hi && credit_ch1 >= credit_lo &&
         credit_ch2 <= credit_hi && credit_ch2 >= credit_lo));

    a_r4_ch1_credit: assert property (@(posedge clk) disable iff (rst)
        ($rose(grant_valid) && grant[1] && !$past(shaper_off[0])) |->
        ($past(credit_ch1) > 0));

    a_r4_ch2_credit: assert property (@(posedge clk) disable iff (rst)
        ($rose(grant_valid) && grant[2] && !($past(shaper_off[0]) && $past(shaper_off[1]))) |->
        ($past(credit_ch2) > 0));

    a_r1_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!grant_valid && credit_ch1 == 0 && credit_ch2 == 0));
endmodule

bind txsched_top txsched_chk #(.CR_W(CR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_end   (frame_end),
    .shaper_off  (shaper_off),
    .credit_hi   (credit_hi),
    .credit_lo   (credit_lo),
    .grant       (grant),
    .grant_valid (grant_valid),
    .credit_ch1  (credit_ch1),
    .credit_ch2  (credit_ch2)
);

// File: tb/txsched_top_test.sv
module txsched_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 4;
    localparam int BYTE_W = 11;
    localparam int CR_W   = 16;

    logic                       clk = 1'b0;
    logic                       rst;
    logic [2:0][CNT_W-1:0]      frame_count;
    logic [2:0][BYTE_W-1:0]     part_bytes;
    logic [2:0]                 frame_start, frame_end;
    logic                       thr_en;
    logic [BYTE_W-1:0]          thr_bytes;
    logic [1:0]                 shaper_off;
    logic [CR_W-1:0]            idle_slope, send_slope;
    logic signed [CR_W-1:0]     credit_hi, credit_lo;
    logic [2:0]                 grant;
    logic                       grant_valid;
    logic signed [CR_W-1:0]     credit_ch1, credit_ch2;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txsched_top #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .CR_W(CR_W)) uut (
        .clk(clk), .rst(rst), .frame_count(frame_count), .part_bytes(part_bytes),
        .frame_start(frame_start), .frame_end(frame_end), .thr_en(thr_en),
        .thr_bytes(thr_bytes), .shaper_off(shaper_off), .idle_slope(idle_slope),
        .send_slope(send_slope), .credit_hi(credit_hi), .credit_lo(credit_lo),
        .grant(grant), .grant_valid(grant_valid),
        .credit_ch1(credit_ch1), .credit_ch2(credit_ch2)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic chk_grant(input string req, input logic [2:0] g);
        chk({req, " grant"}, int'(grant), int'(g));
        chk({req, " valid"}, int'(grant_valid), int'(g != 3'b000));
    endtask

    task automatic do_reset();
        frame_count = '0; part_bytes = '0; frame_start = '0; frame_end = '0;
        thr_en = 0; thr_bytes = 11'd100; shaper_off = 2'b00;
        idle_slope = 16'd10; send_slope = 16'd20;
        credit_hi = 16'sd1000; credit_lo = -16'sd1000;
        rst = 1;
        step(2);
        rst = 0;
    endtask

    task automatic t_reset_and_strict();
        do_reset();
        chk_grant("R1 reset", 3'b000);
        chk("R1 credit1", int'(credit_ch1), 0);
        chk("R1 credit2", int'(credit_ch2), 0);
        frame_count[0] = 4'd1;
        step(1);
        chk_grant("R2 ch0 frame", 3'b001);
        frame_start[0] = 1; step(1); frame_start[0] = 0;
        step(1);
        chk_grant("R2 ch0 sending", 3'b001);
        frame_end[0] = 1; frame_count[0] = 0; step(1); frame_end[0] = 0;
        chk_grant("R10 released", 3'b000);
    endtask

    task automatic t_threshold();
        do_reset();
        part_bytes[0] = 11'd100;
        step(2);
        chk_grant("R3 thr off ignored", 3'b000);
        thr_en = 1; part_bytes[0] = 11'd99;
        step(2);
        chk_grant("R3 below threshold", 3'b000);
        part_bytes[0] = 11'd100;
        step(1);
        chk_grant("R3 at threshold", 3'b001);
        do_reset();
        thr_en = 1; part_bytes[1] = 11'd200;
        step(3);
        chk_grant("R4 shaped ignores threshold", 3'b000);
        shaper_off = 2'b01;
        step(1);
        chk_grant("R8 ch1 plain uses threshold", 3'b010);
    endtask

    task automatic t_credit();
        do_reset();
        frame_count[1] = 4'd1;
        step(1);
        chk("R5 credit rises", int'(credit_ch1), 10);
        chk_grant("R4 zero credit not eligible", 3'b000);
        step(1);
        chk("R5 credit armed", int'(credit_ch1), 20);
        chk_grant("R4 positive credit eligible", 3'b010);
        frame_start[1] = 1; step(1); frame_start[1] = 0;
        chk("R5 armed still gains", int'(credit_ch1), 30);
        step(2);
        chk("R5 send drains", int'(credit_ch1), -10);
        frame_end[1] = 1; frame_count[1] = 0; step(1); frame_end[1] = 0;
        chk("R5 last send cycle", int'(credit_ch1), -30);
        chk_grant("R10 end of frame", 3'b000);
        step(2);
        chk("R6 negative recovers", int'(credit_ch1), -10);
        step(2);
        chk("R6 stops at zero", int'(credit_ch1), 0);
        frame_count[1] = 4'd1;
        step(1);
        chk("R5 rises again", int'(credit_ch1), 10);
        frame_count[1] = 0;
        step(1);
        chk("R6 positive cleared", int'(credit_ch1), 0);
        chk_grant("R4 no frame no grant", 3'b000);
    endtask

    task automatic t_clamp();
        do_reset();
        credit_hi = 16'sd25; credit_lo = -16'sd15;
        frame_count[1] = 4'd1;
        step(4);
        chk("R7 high clamp", int'(credit_ch1), 25);
        frame_start[1] = 1; step(1); frame_start[1] = 0;
        step(3);
        chk("R7 low clamp", int'(credit_ch1), -15);
        frame_end[1] = 1; frame_count[1] = 0; step(1); frame_end[1] = 0;
    endtask

    task automatic t_priority();
        do_reset();
        shaper_off = 2'b11;
        frame_count = {4'd1, 4'd1, 4'd1};
        step(1);
        chk_grant("R9 ch2 first", 3'b100);
        chk("R8 credit2 held zero", int'(credit_ch2), 0);
        frame_start[2] = 1; step(1); frame_start[2] = 0;
        frame_end[2] = 1; frame_count[2] = 0; step(1); frame_end[2] = 0;
        chk_grant("R10 gap after end", 3'b000);
        step(1);
        chk_grant("R9 ch1 next", 3'b010);
        frame_end[1] = 1; frame_count[1] = 0; step(1); frame_end[1] = 0;
        step(1);
        chk_grant("R9 ch0 last", 3'b001);
    endtask

    task automatic t_hold();
        do_reset();
        shaper_off = 2'b11;
        frame_count[0] = 4'd1;
        step(1);
        chk_grant("R10 ch0 granted", 3'b001);
        frame_count[2] = 4'd1;
        step(3);
        chk_grant("R10 higher queue waits", 3'b001);
        frame_end[1] = 1; step(1); frame_end[1] = 0;
        chk_grant("R10 foreign end ignored", 3'b001);
        frame_end[0] = 1; frame_count[0] = 0; step(1); frame_end[0] = 0;
        chk_grant("R10 own end releases", 3'b000);
        step(1);
        chk_grant("R9 then ch2", 3'b100);
    endtask

    task automatic t_disable_modes();
        do_reset();
        shaper_off = 2'b10;
        frame_count[2] = 4'd1;
        step(1);
        chk_grant("R8 illegal keeps ch2 shaped", 3'b000);
        chk("R8 ch2 credit counts", int'(credit_ch2), 10);
        step(1);
        chk_grant("R8 ch2 granted on credit", 3'b100);
        do_reset();
        shaper_off = 2'b01;
        frame_count[1] = 4'd1;
        step(1);
        chk_grant("R8 ch1 plain", 3'b010);
        chk("R8 ch1 credit zero", int'(credit_ch1), 0);
    endtask

    initial begin
        t_reset_and_strict();
        t_threshold();
        t_credit();
        t_clamp();
        t_priority();
        t_hold();
        t_disable_modes();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule